// File: doc/BRIEF.md
# Trapped Instruction Transformer

This block turns the bits of a memory-touching instruction that has just faulted into the compact word a hypervisor-capable core writes into its trap-instruction register. A compressed memory instruction is widened to its 32-bit equivalent. Loads and stores lose their immediates. Atomics and the virtual-machine load/store instructions keep their encoding. In every case the rs1 field is replaced by the byte offset between the faulting address and the instruction's own effective address, masked to the access size. That offset is nonzero only for misaligned accesses. Any instruction that cannot be transformed gives an all-zero word.

The transformation itself is combinational. It sits behind a one-entry valid/ready register slice, so the trap logic can hand over a request and collect the result one cycle later. Flow-control rules:
- A request is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the slice is empty or the consumer is taking the current result in that same cycle.
- A result that has been offered stays valid and unchanged until `out_ready` takes it.

The caller supplies the instruction, the faulting address, the effective address (base register plus immediate) and whether the hart runs with 64-bit XLEN.

Top module: `trap_insn_xform`

## Requirements
- R1: A compressed instruction (bits 1:0 = 00, quadrant 0) is expanded from its funct3 (bits 15:13). The data register is 8 plus bits 4:2; it goes to rd (bits 11:7) for loads and to rs2 (bits 24:20) for stores. The codes are:
  - 1 → FLD: opcode 0x07, funct3 3, size 8.
  - 2 → LW: opcode 0x03, funct3 2, size 4.
  - 5 → FSD: opcode 0x27, funct3 3, size 8.
  - 6 → SW: opcode 0x23, funct3 2, size 4.
- R2: Quadrant 2 (bits 1:0 = 10) uses the same funct3 codes as R1 (and R3). The load destination comes from bits 11:7 and the store source from bits 6:2.
- R3: Compressed funct3 3 gives FLW (opcode 0x07, funct3 2, size 4) at 32-bit XLEN and LD (0x03, funct3 3, size 8) at 64-bit XLEN. Compressed funct3 7 gives FSW (0x27, funct3 2, size 4) or SD (0x23, funct3 3, size 8) the same way.
- R4: Every expanded compressed result has bit 1 cleared. An uncompressed transformable result keeps bits 1:0 = 11.
- R5: Quadrant 1 and the compressed funct3 codes 0 and 4 give an all-zero result.
- R6: Uncompressed loads (0x03, 0x07) keep their encoding with bits 31:20 zeroed. Stores (0x23, 0x27) keep theirs with bits 31:25 and 11:7 zeroed. Atomics (0x2F) keep every bit. In all three cases log2 of the size is funct3 (bits 14:12).
- R7: A SYSTEM instruction (0x73) with funct3 4 keeps its encoding, and log2 of its size is bits 27:26. Any other SYSTEM instruction gives zero.
- R8: In every transformed result, bits 19:15 hold (fault address − effective address) AND (size − 1), taken modulo 32.
- R9: Any other major opcode gives an all-zero result.
- R10: A request accepted at a clock edge appears on `out_tinst` with `out_valid` high right after that edge. `in_ready` equals NOT `out_valid` OR `out_ready`. A result that is not yet taken holds its value.
- R11: While reset is held, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Slice can take a request |
| in_insn | input | 32 | Faulting instruction (low 16 bits when compressed) |
| in_fault_addr | input | ADDR_W | Faulting address |
| in_eff_addr | input | ADDR_W | Effective address of the instruction |
| in_xlen64 | input | 1 | 1 for 64-bit XLEN, 0 for 32-bit |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_tinst | output | 32 | Transformed instruction word |

## Verification
Every result is due exactly one clock edge after its request is accepted. The bench records each accepted request in a queue together with the expected word, and compares the head of the queue whenever the consumer takes a result. Because back-pressure can delay the result, no check depends on a fixed cycle count except the first one: that request is sent into an empty, unstalled slice, and the bench checks that it is visible right after the following edge. While a result is stalled, the bench checks in every stalled cycle that it keeps its value.

// File: rtl/tix_pkg.sv
package tix_pkg;
  localparam logic [6:0] OPC_LOAD     = 7'h03;
  localparam logic [6:0] OPC_LOAD_FP  = 7'h07;
  localparam logic [6:0] OPC_STORE    = 7'h23;
  localparam logic [6:0] OPC_STORE_FP = 7'h27;
  localparam logic [6:0] OPC_AMO      = 7'h2F;
  localparam logic [6:0] OPC_SYSTEM   = 7'h73;
  localparam logic [2:0] F3_HYP_MEM   = 3'd4;
  localparam int         RS1_LSB      = 15;
  localparam int         RS1_W        = 5;

  typedef struct packed {
    logic        hit;
    logic [31:0] word;
    logic [2:0]  lg_size;
  } xf_t;

  function automatic logic [31:0] mk_load(logic [6:0] opc, logic [2:0] f3, logic [4:0] rd);
    return {12'b0, 5'b0, f3, rd, opc};
  endfunction

  function automatic logic [31:0] mk_store(logic [6:0] opc, logic [2:0] f3, logic [4:0] rs2);
    return {7'b0, rs2, 5'b0, f3, 5'b0, opc};
  endfunction
endpackage

// File: rtl/tix_rvc_expand.sv
module tix_rvc_expand
  import tix_pkg::*;
(
  input  logic [15:0] cinsn,
  input  logic        xlen64,
  output xf_t         res
);
  logic [1:0] quad;
  logic [2:0] f3;
  logic [4:0] ld_reg;
  logic [4:0] st_reg;
  logic       unused_imm;

  assign quad       = cinsn[1:0];
  assign f3         = cinsn[15:13];
  assign unused_imm = cinsn[12];

  always_comb begin
    if (quad == 2'b00) begin
      ld_reg = {2'b01, cinsn[4:2]};
      st_reg = {2'b01, cinsn[4:2]};
    end else begin
      ld_reg = cinsn[11:7];
      st_reg = cinsn[6:2];
    end
  end

  always_comb begin
    res = '0;
    if (quad == 2'b00 || quad == 2'b10) begin
      unique case (f3)
        3'd1: res = '{hit: 1'b1, word: mk_load(OPC_LOAD_FP, 3'd3, ld_reg), lg_size: 3'd3};
        3'd2: res = '{hit: 1'b1, word: mk_load(OPC_LOAD, 3'd2, ld_reg), lg_size: 3'd2};
        3'd3: begin
          if (xlen64) res = '{hit: 1'b1, word: mk_load(OPC_LOAD, 3'd3, ld_reg), lg_size: 3'd3};
          else        res = '{hit: 1'b1, word: mk_load(OPC_LOAD_FP, 3'd2, ld_reg), lg_size: 3'd2};
        end
        3'd5: res = '{hit: 1'b1, word: mk_store(OPC_STORE_FP, 3'd3, st_reg), lg_size: 3'd3};
        3'd6: res = '{hit: 1'b1, word: mk_store(OPC_STORE, 3'd2, st_reg), lg_size: 3'd2};
        3'd7: begin
          if (xlen64) res = '{hit: 1'b1, word: mk_store(OPC_STORE, 3'd3, st_reg), lg_size: 3'd3};
          else        res = '{hit: 1'b1, word: mk_store(OPC_STORE_FP, 3'd2, st_reg), lg_size: 3'd2};
        end
        default: res = '0;
      endcase
      // compressed origin mark
      res.word[1] = 1'b0;
    end
  end
endmodule

// File: rtl/tix_wide_xform.sv
module tix_wide_xform
  import tix_pkg::*;
(
  input  logic [31:0] insn,
  output xf_t         res
);
  logic [6:0] opc;
  logic [2:0] f3;

  assign opc = insn[6:0];
  assign f3  = insn[14:12];

  always_comb begin
    res = '0;
    unique case (opc)
      OPC_LOAD, OPC_LOAD_FP:
        res = '{hit: 1'b1, word: {12'b0, insn[19:0]}, lg_size: f3};
      OPC_STORE, OPC_STORE_FP:
        res = '{hit: 1'b1, word: {7'b0, insn[24:12], 5'b0, insn[6:0]}, lg_size: f3};
      OPC_AMO:
        res = '{hit: 1'b1, word: insn, lg_size: f3};
      OPC_SYSTEM: begin
        if (f3 == F3_HYP_MEM)
          res = '{hit: 1'b1, word: insn, lg_size: {1'b0, insn[27:26]}};
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/tix_offset_fold.sv
module tix_offset_fold
  import tix_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  xf_t               res,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic [ADDR_W-1:0] eff_addr,
  output logic [31:0]       tinst
);
  localparam int LG_ALL = RS1_W;

  logic [RS1_W-1:0] diff;
  logic [RS1_W-1:0] mask;
  logic             unused_hi;

  assign diff      = fault_addr[RS1_W-1:0] - eff_addr[RS1_W-1:0];
  assign unused_hi = ^{fault_addr[ADDR_W-1:RS1_W], eff_addr[ADDR_W-1:RS1_W]};

  always_comb begin
    if (int'(res.lg_size) >= LG_ALL) mask = '1;
    else mask = RS1_W'((1 << res.lg_size) - 1);
  end

  always_comb begin
    tinst = '0;
    if (res.hit) begin
      tinst = res.word;
      tinst[RS1_LSB +: RS1_W] = diff & mask;
    end
  end
endmodule

// File: rtl/trap_insn_xform.sv
module trap_insn_xform
  import tix_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_insn,
  input  logic [ADDR_W-1:0] in_fault_addr,
  input  logic [ADDR_W-1:0] in_eff_addr,
  input  logic              in_xlen64,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_tinst
);
  xf_t         rvc_res;
  xf_t         wide_res;
  xf_t         sel_res;
  logic [31:0] xf_word;
  logic        is_rvc;

  assign is_rvc = (in_insn[1:0] != 2'b11);

  tix_rvc_expand u_rvc (
    .cinsn (in_insn[15:0]),
    .xlen64(in_xlen64),
    .res   (rvc_res)
  );

  tix_wide_xform u_wide (
    .insn(in_insn),
    .res (wide_res)
  );

  assign sel_res = is_rvc ? rvc_res : wide_res;

  tix_offset_fold #(.ADDR_W(ADDR_W)) u_fold (
    .res       (sel_res),
    .fault_addr(in_fault_addr),
    .eff_addr  (in_eff_addr),
    .tinst     (xf_word)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_tinst <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_tinst <= xf_word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tix_checker.sv
module tix_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_tinst
);
  logic [6:0] op;
  logic       op_known;
  assign op = out_tinst[6:0];
  assign op_known = op inside {7'h03, 7'h07, 7'h23, 7'h27, 7'h2F, 7'h73,
                               7'h01, 7'h05, 7'h21, 7'h25};

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_tinst));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R10
  accept_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R4
  low_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_tinst != 32'h0 |-> out_tinst[0]);

  // R9
  opcode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_tinst != 32'h0 |-> op_known);
endmodule

bind trap_insn_xform tix_checker chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_tinst(out_tinst)
);

// File: tb/trap_insn_xform_tb_top.sv
`timescale 1ns/10ps
module trap_insn_xform_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic [63:0] in_fault_addr = '0;
  logic [63:0] in_eff_addr = '0;
  logic        in_xlen64 = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_tinst;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit bp_en  = 1'b0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  trap_insn_xform #(.ADDR_W(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_fault_addr(in_fault_addr), .in_eff_addr(in_eff_addr),
    .in_xlen64(in_xlen64), .out_valid(out_valid), .out_ready(out_ready),
    .out_tinst(out_tinst)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_xf(input logic [31:0] i, input logic [63:0] fa,
                                         input logic [63:0] ea, input bit x64);
    logic [31:0] w = '0;
    int lg = 0;
    bit hit = 0;
    logic [4:0] rd_r, rs_r, off, m;
    if (i[1:0] != 2'b11) begin
      rd_r = (i[1:0] == 2'b00) ? {2'b01, i[4:2]} : i[11:7];
      rs_r = (i[1:0] == 2'b00) ? {2'b01, i[4:2]} : i[6:2];
      if (i[1:0] != 2'b01) begin
        hit = 1;
        case (i[15:13])
          3'd1: begin w = {17'b0, 3'd3, rd_r, 7'h07}; lg = 3; end
          3'd2: begin w = {17'b0, 3'd2, rd_r, 7'h03}; lg = 2; end
          3'd3: if (x64) begin w = {17'b0, 3'd3, rd_r, 7'h03}; lg = 3; end
                else     begin w = {17'b0, 3'd2, rd_r, 7'h07}; lg = 2; end
          3'd5: begin w = {7'b0, rs_r, 5'b0, 3'd3, 5'b0, 7'h27}; lg = 3; end
          3'd6: begin w = {7'b0, rs_r, 5'b0, 3'd2, 5'b0, 7'h23}; lg = 2; end
          3'd7: if (x64) begin w = {7'b0, rs_r, 5'b0, 3'd3, 5'b0, 7'h23}; lg = 3; end
                else     begin w = {7'b0, rs_r, 5'b0, 3'd2, 5'b0, 7'h27}; lg = 2; end
          default: hit = 0;
        endcase
        w[1] = 1'b0;
      end
    end else begin
      hit = 1;
      lg = int'(i[14:12]);
      case (i[6:0])
        7'h03, 7'h07: w = i & 32'h000F_FFFF;
        7'h23, 7'h27: w = i & 32'h01FF_F07F;
        7'h2F:        w = i;
        7'h73: if (i[14:12] == 3'd4) begin w = i; lg = int'(i[27:26]); end
               else hit = 0;
        default: hit = 0;
      endcase
    end
    if (!hit) return 32'h0;
    off = fa[4:0] - ea[4:0];
    m = (lg >= 5) ? 5'h1f : 5'((1 << lg) - 1);
    w[19:15] = off & m;
    return w;
  endfunction

  // driver: pushes the expected item once the request is accepted
  task automatic send(input logic [31:0] i, input logic [63:0] fa, input logic [63:0] ea,
                      input bit x64, input string tag);
    @(negedge clk);
    #0.2;
    in_insn = i; in_fault_addr = fa; in_eff_addr = ea; in_xlen64 = x64; in_valid = 1'b1;
    #0.2;
    while (!in_ready) begin
      @(negedge clk);
      #0.4;
    end
    exp_q.push_back(ref_xf(i, fa, ea, x64));
    tag_q.push_back(tag);
    @(posedge clk);
    #0.2;
    in_valid = 1'b0;
  endtask

  // consumer back-pressure
  always @(negedge clk) begin
    cyc++;
    out_ready = bp_en ? ((cyc % 5) != 3) : 1'b1;
  end

  // monitor
  logic [31:0] held = '0;
  bit          was_stalled = 1'b0;
  always @(negedge clk) begin
    #0.6;
    if (rst_n) begin
      if (was_stalled && out_valid)
        check(out_tinst == held, "R10 hold", out_tinst, held);
      was_stalled = out_valid && !out_ready;
      held = out_tinst;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected result", out_tinst, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_tinst === e, t, out_tinst, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 32'h0, 32'h1);
      finish_run();
    end
  end

  initial begin
    logic [63:0] ea;
    // R11: reset state
    repeat (3) @(negedge clk);
    #0.6;
    check(out_valid == 1'b0, "R11 out_valid in reset", {31'b0, out_valid}, 32'h0);
    check(in_ready == 1'b1, "R11 in_ready in reset", {31'b0, in_ready}, 32'h1);
    rst_n = 1'b1;

    // R10: latency of one edge from an empty slice
    @(negedge clk);
    #0.2;
    in_insn = 32'h0085_2503; in_fault_addr = 64'h1002; in_eff_addr = 64'h1000;
    in_xlen64 = 1'b1; in_valid = 1'b1;
    exp_q.push_back(ref_xf(32'h0085_2503, 64'h1002, 64'h1000, 1'b1));
    tag_q.push_back("R10 first result");
    @(posedge clk);
    #0.2;
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R10 latency", {31'b0, out_valid}, 32'h1);

    bp_en = 1'b1;

    // R1 R2 R3 R5 R8: every compressed quadrant 0/2 code at both XLEN
    for (int q = 0; q < 3; q++) begin
      for (int f = 0; f < 8; f++) begin
        for (int x = 0; x < 2; x++) begin
          for (int o = 0; o < 4; o++) begin
            logic [10:0] mid;
            logic [31:0] ci;
            int offs;
            string tg;
            offs = (o == 0) ? 0 : (o == 1) ? 1 : (o == 2) ? 3 : 6;
            mid = 11'(q * 311 + f * 97 + o * 53 + x * 29 + 7);
            ci = {16'hA5A5, 3'(f), mid, 2'(q)};
            ea = 64'h0000_0040_0000_1000 + 64'(f * 16 + o * 8);
            if (q == 1 || f == 0 || f == 4) tg = "R5";
            else if (offs != 0) tg = "R8";
            else if (f == 3 || f == 7) tg = "R3";
            else tg = (q == 0) ? "R1" : "R2";
            send(ci, ea + 64'(offs), ea, x[0], tg);
          end
        end
      end
    end

    // R4: compressed versus uncompressed store marking
    send(32'h0000_C18C, 64'h2000, 64'h2000, 1'b0, "R4");
    send(32'h00B5_2223, 64'h2000, 64'h2000, 1'b0, "R4");

    // R6: uncompressed loads with immediates, stores, FP forms, atomics
    for (int f = 0; f < 7; f++) begin
      logic [31:0] li;
      li = {12'hFED, 5'd11, 3'(f), 5'd9, 7'h03};
      send(li, 64'h3000, 64'h3000, 1'b1, "R6");
      send(li, 64'h3005, 64'h3000, 1'b1, "R8");
    end
    send(32'hFFF3_3407, 64'h4000, 64'h4000, 1'b1, "R6");
    send(32'hFE73_BFA3, 64'h4001, 64'h4000, 1'b1, "R8");
    send(32'h80C5_A527, 64'h4000, 64'h4000, 1'b0, "R6");
    send(32'h08B5_A52F, 64'h4000, 64'h4000, 1'b1, "R6");
    send(32'h08B5_B52F, 64'h4003, 64'h4000, 1'b1, "R8");
    // R8: offset with the fault below the effective address
    send(32'h0005_2503, 64'h4FFE, 64'h5000, 1'b1, "R8");
    // R8: offset truncated to the 5-bit field for funct3 7
    send(32'h0005_7503, 64'h5000 + 64'd45, 64'h5000, 1'b1, "R8");

    // R7: virtual-machine loads/stores of each size; other SYSTEM forms
    for (int s = 0; s < 4; s++) begin
      logic [31:0] hi;
      hi = {4'b0110, 2'(s), 1'b0, 5'd0, 5'd10, 3'd4, 5'd12, 7'h73};
      send(hi, 64'h6000, 64'h6000, 1'b1, "R7");
      send(hi, 64'h6007, 64'h6000, 1'b1, "R8");
    end
    send(32'h3400_1073, 64'h6000, 64'h6000, 1'b1, "R7");
    send(32'h0000_0073, 64'h6000, 64'h6000, 1'b1, "R7");

    // R9: other major opcodes
    send(32'h00B5_0533, 64'h7000, 64'h7000, 1'b1, "R9");
    send(32'h0080_006F, 64'h7000, 64'h7000, 1'b1, "R9");
    send(32'h0015_0513, 64'h7001, 64'h7000, 1'b1, "R9");

    // drain
    for (int w = 0; w < 200 && (exp_q.size() != 0 || out_valid); w++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R10 drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    finish_run();
  end
endmodule